// File: doc/BRIEF.md
# Serial Programmable-Flag Offset Loader

This block holds the almost-empty and almost-full threshold offsets of a FIFO and lets them be reprogrammed through a single serial data pin sampled on the write clock. While both the active-low load strobe and the active-low serial enable are low, each rising write-clock edge captures one bit. The bits fill one chain twice the offset width long. The first bit is the least significant bit of the almost-empty offset. The last bit is the most significant bit of the almost-full offset.

Neither offset can be rewritten alone. The two offset outputs keep their previous values until the final bit of a pass is captured, and then both change together. Raising either strobe pauses the chain without losing the bit position, so that ordinary FIFO writes can run between bits. The first bit of a new pass marks both flags invalid. The almost-full valid indication, which lives in the write-clock domain, comes back two write-clock edges after the pass completes. The almost-empty valid indication, which lives in the read-clock domain, comes back on the second read-clock edge after completion. The offsets cannot be read back through the serial path.

Top module: `sflag_loader`

## Requirements
- R1: While `rst` is high, the bit position returns to zero, `ae_offset` and `af_offset` take the parameter defaults, and both `af_valid` and `ae_valid` read 1.
- R2: On a write-clock rising edge with `ld_n`=0 and `sen_n`=0, `sdi` is captured into the next chain position. Chain position k (0 to 2W-1) maps to `ae_offset[k]` for k<W and to `af_offset[k-W]` otherwise.
- R3: With `ld_n`=0 and `sen_n`=1, no bit is captured and the chain position does not advance.
- R4: With `ld_n`=1, whatever the value of `sen_n`, capture is paused. When both strobes are low again, loading continues at the next position in sequence.
- R5: `ae_offset` and `af_offset` change only on the edge that captures the last chain position, and both are updated together on that edge.
- R6: The edge that captures position 0 drives `af_valid` low after that edge. `ae_valid` goes low after the second read-clock edge that follows.
- R7: `af_valid` returns high after the second write-clock edge following the edge that captured the last chain position.
- R8: `ae_valid` returns high after the second read-clock rising edge following the edge that captured the last chain position.
- R9: If a new pass starts before the two-edge wait of R7 has elapsed, `af_valid` stays low and the pending return is cancelled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock; serial capture clock |
| rd_clk | input | 1 | Read clock; almost-empty valid domain |
| rst | input | 1 | Synchronous active-high master reset, held across edges of both clocks |
| ld_n | input | 1 | Active-low load strobe |
| sen_n | input | 1 | Active-low serial enable |
| sdi | input | 1 | Serial offset data |
| ae_offset | output | OFS_W | Almost-empty offset |
| af_offset | output | OFS_W | Almost-full offset |
| af_valid | output | 1 | Almost-full offset usable (write domain) |
| ae_valid | output | 1 | Almost-empty offset usable (read domain) |

## Verification
Two events can land on the same write-clock edge. The final bit of one pass can complete while the almost-full wait from a previous pass is still pending. The first bit of a new pass can also arrive inside the two-edge return window of the pass that just finished. The bench provokes the second case by starting a pass on the very next edge after a completion. It then judges, against its own per-cycle model, that `af_valid` never rises and that the new bits go to position zero onward. The two clocks are set to periods whose edges never coincide, so the almost-empty return can be counted in read-clock edges without ambiguity.

// File: rtl/sflag_pkg.sv
package sflag_pkg;

    typedef enum logic [1:0] {
        OP_SHIFT   = 2'd0,
        OP_BLOCKED = 2'd1,
        OP_PAUSED  = 2'd2
    } ser_op_e;

    typedef struct packed {
        logic start;
        logic finish;
    } chain_evt_t;

    function automatic ser_op_e decode_op(input logic ld_n, input logic sen_n);
        if (ld_n)
            return OP_PAUSED;
        else if (sen_n)
            return OP_BLOCKED;
        else
            return OP_SHIFT;
    endfunction

    localparam int unsigned AF_RETURN_EDGES = 2;

endpackage

// File: rtl/sflag_chain.sv
module sflag_chain
    import sflag_pkg::*;
#(
    parameter int unsigned     OFS_W      = 16,
    parameter logic [OFS_W-1:0] AE_DEFAULT = '0,
    parameter logic [OFS_W-1:0] AF_DEFAULT = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift,
    input  logic             sdi,
    output logic [OFS_W-1:0] ae_q,
    output logic [OFS_W-1:0] af_q,
    output chain_evt_t       evt
);
    localparam int unsigned CHAIN_LEN = 2 * OFS_W;
    localparam int unsigned CW        = $clog2(CHAIN_LEN);
    localparam logic [CW-1:0] LAST_POS = CW'(CHAIN_LEN - 1);

    logic [CW-1:0]        pos;
    logic [CHAIN_LEN-1:0] stage;
    logic [CHAIN_LEN-1:0] merged;

    always_comb begin
        merged      = stage;
        merged[pos] = sdi;
    end

    assign evt.start  = shift && (pos == '0);
    assign evt.finish = shift && (pos == LAST_POS);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos   <= '0;
            stage <= '0;
            ae_q  <= AE_DEFAULT;
            af_q  <= AF_DEFAULT;
        end else if (shift) begin
            stage[pos] <= sdi;
            if (pos == LAST_POS) begin
                pos  <= '0;
                ae_q <= merged[OFS_W-1:0];
                af_q <= merged[CHAIN_LEN-1:OFS_W];
            end else begin
                pos <= pos + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sflag_wr_valid.sv
module sflag_wr_valid
    import sflag_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  chain_evt_t evt,
    output logic       af_valid,
    output logic       cfg_done
);
    logic [AF_RETURN_EDGES-1:0] wait_pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            af_valid  <= 1'b1;
            cfg_done  <= 1'b1;
            wait_pipe <= '0;
        end else if (evt.start) begin
            af_valid  <= 1'b0;
            cfg_done  <= 1'b0;
            wait_pipe <= '0;
        end else begin
            wait_pipe <= {wait_pipe[AF_RETURN_EDGES-2:0], evt.finish};
            if (evt.finish)
                cfg_done <= 1'b1;
            if (wait_pipe[AF_RETURN_EDGES-1])
                af_valid <= 1'b1;
        end
    end

endmodule

// File: rtl/sflag_rd_valid.sv
module sflag_rd_valid
    import sflag_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cfg_done,
    output logic ae_valid
);
    logic [1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst)
            sync_q <= 2'b11;
        else
            sync_q <= {sync_q[0], cfg_done};
    end

    assign ae_valid = sync_q[1];

endmodule

// File: rtl/sflag_loader.sv
module sflag_loader
    import sflag_pkg::*;
#(
    parameter int unsigned      OFS_W      = 16,
    parameter logic [OFS_W-1:0] AE_DEFAULT = OFS_W'(16'h007F),
    parameter logic [OFS_W-1:0] AF_DEFAULT = OFS_W'(16'h00FF)
) (
    input  logic             wr_clk,
    input  logic             rd_clk,
    input  logic             rst,
    input  logic             ld_n,
    input  logic             sen_n,
    input  logic             sdi,
    output logic [OFS_W-1:0] ae_offset,
    output logic [OFS_W-1:0] af_offset,
    output logic             af_valid,
    output logic             ae_valid
);
    ser_op_e    op;
    logic       shift;
    chain_evt_t evt;
    logic       cfg_done;

    assign op    = decode_op(ld_n, sen_n);
    assign shift = (op == OP_SHIFT);

    sflag_chain #(
        .OFS_W      (OFS_W),
        .AE_DEFAULT (AE_DEFAULT),
        .AF_DEFAULT (AF_DEFAULT)
    ) u_chain (
        .clk   (wr_clk),
        .rst   (rst),
        .shift (shift),
        .sdi   (sdi),
        .ae_q  (ae_offset),
        .af_q  (af_offset),
        .evt   (evt)
    );

    sflag_wr_valid u_wr_valid (
        .clk      (wr_clk),
        .rst      (rst),
        .evt      (evt),
        .af_valid (af_valid),
        .cfg_done (cfg_done)
    );

    sflag_rd_valid u_rd_valid (
        .clk      (rd_clk),
        .rst      (rst),
        .cfg_done (cfg_done),
        .ae_valid (ae_valid)
    );

endmodule

// File: rtl/sflag_loader_chk.sv
module sflag_loader_chk #(
    parameter int unsigned      OFS_W      = 16,
    parameter logic [OFS_W-1:0] AE_DEFAULT = '0,
    parameter logic [OFS_W-1:0] AF_DEFAULT = '0
) (
    input logic             wr_clk,
    input logic             rst,
    input logic             ld_n,
    input logic             sen_n,
    input logic [OFS_W-1:0] ae_offset,
    input logic [OFS_W-1:0] af_offset,
    input logic             af_valid
);
    localparam int unsigned CW = $clog2(2 * OFS_W);
    localparam logic [CW-1:0] LAST_POS = CW'(2 * OFS_W - 1);

    logic [CW-1:0] seen;
    logic          cap;
    logic          last_cap;

    assign cap      = !ld_n && !sen_n;
    assign last_cap = cap && (seen == LAST_POS);

    always_ff @(posedge wr_clk) begin
        if (rst)
            seen <= '0;
        else if (cap)
            seen <= (seen == LAST_POS) ? '0 : seen + 1'b1;
    end

    // R1: reset state
    a_r1_reset_state: assert property (@(posedge wr_clk)
        rst |=> (af_valid && ae_offset == AE_DEFAULT && af_offset == AF_DEFAULT));

    // R3, R4: blocked or paused edges leave the offsets alone
    a_r3_blocked_hold: assert property (@(posedge wr_clk) disable iff (rst)
        (!ld_n && sen_n) |=> ($stable(ae_offset) && $stable(af_offset)));

    a_r4_paused_hold: assert property (@(posedge wr_clk) disable iff (rst)
        ld_n |=> ($stable(ae_offset) && $stable(af_offset)));

    // R5: offsets move only at the last chain position
    a_r5_commit_only: assert property (@(posedge wr_clk) disable iff (rst)
        !last_cap |=> ($stable(ae_offset) && $stable(af_offset)));

    // R6: a new pass drops the almost-full valid
    a_r6_start_clears: assert property (@(posedge wr_clk) disable iff (rst)
        (cap && seen == '0) |=> !af_valid);

    // R7: almost-full valid returns two edges after completion
    a_r7_af_return: assert property (@(posedge wr_clk) disable iff (rst)
        $rose(af_valid) |-> $past(last_cap, 3));

endmodule

bind sflag_loader sflag_loader_chk #(
    .OFS_W      (OFS_W),
    .AE_DEFAULT (AE_DEFAULT),
    .AF_DEFAULT (AF_DEFAULT)
) i_sflag_loader_chk (
    .wr_clk    (wr_clk),
    .rst       (rst),
    .ld_n      (ld_n),
    .sen_n     (sen_n),
    .ae_offset (ae_offset),
    .af_offset (af_offset),
    .af_valid  (af_valid)
);

// File: tb/test_sflag_loader.sv
`timescale 1ns/1ps
module test_sflag_loader;
    localparam int  CLK_PERIOD = 10;
    localparam real RD_HALF    = 6.3;
    localparam int  W          = 16;
    localparam logic [W-1:0] AE_DEF = 16'h007F;
    localparam logic [W-1:0] AF_DEF = 16'h00FF;

    logic wr_clk = 1'b0, rd_clk = 1'b0;
    logic rst = 1'b1, ld_n = 1'b1, sen_n = 1'b1, sdi = 1'b0;
    logic [W-1:0] ae_offset, af_offset;
    logic af_valid, ae_valid;

    int errors = 0, checks = 0;
    bit started = 0, ended = 0;

    always #(CLK_PERIOD / 2) wr_clk = ~wr_clk;
    always #(RD_HALF) rd_clk = ~rd_clk;

    sflag_loader #(.OFS_W(W), .AE_DEFAULT(AE_DEF), .AF_DEFAULT(AF_DEF)) i_sflag_loader (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .ld_n(ld_n), .sen_n(sen_n),
        .sdi(sdi), .ae_offset(ae_offset), .af_offset(af_offset),
        .af_valid(af_valid), .ae_valid(ae_valid));

    // behavioural reference model
    int           m_pos;
    logic [2*W-1:0] m_stage;
    logic [W-1:0] m_ae, m_af;
    bit           m_done, m_afv, m_aev;
    int           m_wait;
    bit           q_rd[$];

    always @(posedge wr_clk) begin
        if (rst) begin
            m_pos = 0; m_ae = AE_DEF; m_af = AF_DEF;
            m_done = 1; m_afv = 1; m_wait = 0;
        end else if (!ld_n && !sen_n && m_pos == 0) begin
            m_done = 0; m_afv = 0; m_wait = 0;
            m_stage[0] = sdi; m_pos = 1;
        end else begin
            if (m_wait > 0) begin
                m_wait--;
                if (m_wait == 0) m_afv = 1;
            end
            if (!ld_n && !sen_n) begin
                m_stage[m_pos] = sdi;
                if (m_pos == 2*W-1) begin
                    m_ae = m_stage[W-1:0]; m_af = m_stage[2*W-1:W];
                    m_done = 1; m_wait = 2; m_pos = 0;
                end else m_pos++;
            end
        end
    end

    always @(posedge rd_clk) begin
        if (rst) begin
            q_rd = {1'b1, 1'b1}; m_aev = 1;
        end else begin
            q_rd.push_back(m_done);
            void'(q_rd.pop_front());
            m_aev = q_rd[0];
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge wr_clk) begin
        if (started && !ended) begin
            check("R2/R5 ae_offset", 32'(ae_offset), 32'(m_ae));
            check("R2/R5 af_offset", 32'(af_offset), 32'(m_af));
            check("R6/R7/R9 af_valid", 32'(af_valid), 32'(m_afv));
            check("R6/R8 ae_valid", 32'(ae_valid), 32'(m_aev));
        end
    end

    task automatic drive(logic l, logic s, logic d);
        @(negedge wr_clk); #1;
        ld_n = l; sen_n = s; sdi = d;
    endtask

    // pause_every > 0 inserts stalls of rotating kinds (R3 and R4)
    task automatic load_chain(logic [2*W-1:0] val, int pause_every);
        for (int i = 0; i < 2*W; i++) begin
            if (pause_every > 0 && (i % pause_every) == pause_every - 1) begin
                case (i % 3)
                    0: drive(1'b1, 1'b0, ~val[i]);
                    1: drive(1'b0, 1'b1, ~val[i]);
                    default: drive(1'b1, 1'b1, ~val[i]);
                endcase
                drive(1'b0, 1'b1, val[i]);
            end
            drive(1'b0, 1'b0, val[i]);
        end
        drive(1'b1, 1'b1, 1'b0);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(1'b1, 1'b1, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        ended = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1;
        repeat (6) @(negedge wr_clk);
        started = 1;
        #1 rst = 0;
        @(negedge wr_clk); #2;
        // R1: reset values
        check("R1 ae default", 32'(ae_offset), 32'(AE_DEF));
        check("R1 af default", 32'(af_offset), 32'(AF_DEF));
        check("R1 valids", {30'b0, af_valid, ae_valid}, 32'h3);

        // R2: uninterrupted pass
        load_chain({16'hBEEF, 16'h1234}, 0);
        idle(6);
        check("R2 ae value", 32'(ae_offset), 32'h1234);
        check("R2 af value", 32'(af_offset), 32'hBEEF);
        check("R7/R8 both valid", {30'b0, af_valid, ae_valid}, 32'h3);

        // R3, R4: paused pass, offsets must hold in between (R5)
        load_chain({16'h0F0F, 16'hA5C3}, 5);
        idle(6);
        check("R4 ae after pauses", 32'(ae_offset), 32'hA5C3);
        check("R4 af after pauses", 32'(af_offset), 32'h0F0F);

        // R9: new pass begins on the edge right after completion
        for (int i = 0; i < 2*W; i++) drive(1'b0, 1'b0, i[0]);
        drive(1'b0, 1'b0, 1'b1);
        check("R9 af stays low", 32'(af_valid), 32'h0);
        for (int i = 1; i < 2*W; i++) drive(1'b0, 1'b0, 1'b0);
        idle(6);
        check("R9 ae second pass", 32'(ae_offset), 32'h0001);
        check("R9 af second pass", 32'(af_offset), 32'h0000);

        // R1: reset mid-chain then a fresh pass from position zero
        for (int i = 0; i < 7; i++) drive(1'b0, 1'b0, 1'b1);
        drive(1'b1, 1'b1, 1'b0);
        rst = 1; idle(5);
        @(negedge wr_clk); #1 rst = 0;
        idle(1);
        check("R1 mid-chain reset ae", 32'(ae_offset), 32'(AE_DEF));
        load_chain({16'h8001, 16'h7FFE}, 7);
        idle(6);
        check("R1 pos zero after reset ae", 32'(ae_offset), 32'h7FFE);
        check("R1 pos zero after reset af", 32'(af_offset), 32'h8001);

        ended = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule